// File: doc/BRIEF.md
# Parallel Reservoir Patch Selector

This block is used while a convolutional clause-based learner is being trained. Each clause is evaluated on every patch position of the input image, which gives one match bit for each (clause, patch) pair. For its feedback step, each clause then needs one patch chosen at random, with equal chance, from the positions where it matched. The selector does this for every clause at the same time.

After a start strobe, the block takes a snapshot of the match matrix. It then walks the patch positions in raster order, one position per clock. Each clause runs its own streaming reservoir sampler. On the k-th matching position the clause keeps that position with probability 1/k. The 1/k test compares a fresh pseudo-random word, multiplied by k, against the full word range. Every clause has its own LFSR with its own seed, and each LFSR advances one full word per clock, so the clauses draw independently. When the walk is finished, a one-cycle done pulse marks the per-clause index and match-flag outputs as valid.

Top module: `patch_reservoir_sel`

## Requirements
- R1: While idle, a high `start_i` at a rising clock edge is accepted. The block stores `match_i` from that edge and starts a new walk, and it clears every clause's index to 0 and match flag to 0.
- R2: If a start is accepted at edge t, `done_o` is high for exactly one cycle, after edge t+N_PATCHES. Positions 0 through N_PATCHES-1 are visited in order, one per edge.
- R3: At done, `any_o[c]` is 1 exactly when row c of the stored match matrix has at least one bit set. Bit p of row c is clause c's result on patch p.
- R4: When `any_o[c]` is 0, `idx_o[c]` is 0.
- R5: At done, when `any_o[c]` is 1, `idx_o[c]` is a patch index p < N_PATCHES with bit p of row c set.
- R6: A clause with exactly one matching patch reports that patch's index.
- R7: When a clause matches every patch, the index frequencies are uniform across positions within statistical tolerance. When it matches exactly two patches, each one is chosen about half the time.
- R8: Different clauses make independent picks. For clauses that match every patch, neighbouring clauses report the same index about 1/N_PATCHES of the time, not systematically.
- R9: A start strobe during a walk is ignored. The walk in progress keeps its stored matrix and its timing, and no extra done pulse follows.
- R10: After done, `idx_o` and `any_o` stay unchanged until the next accepted start.
- R11: During reset, `done_o`, `any_o` and `idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| match_i | input | N_CLAUSES x N_PATCHES | Match matrix; bit [c][p] means clause c is true on patch p |
| idx_o | output | N_CLAUSES x IDX_W | Selected patch index per clause |
| any_o | output | N_CLAUSES | Clause matched at least one patch |
| done_o | output | 1 | One-cycle pulse; outputs valid from here |

## Verification
Random sparse matrices test that the pick always lands on a set bit, and rows that are empty or have a single bit separate the zero-index rule from the exact-pick rule. Long runs with all patches matching, and runs with exactly two patches matching, build histograms. A sampler that favours early or late positions, or uses a skewed 1/k threshold, shows up in those histograms. Counting how often neighbouring clauses agree shows whether the random sources are shared. A second start issued in the middle of a walk, with a different matrix, shows whether the snapshot and the timing are protected.

// File: rtl/patch_sel_pkg.sv
package patch_sel_pkg;

  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_SCAN = 1'b1
  } sel_state_e;

  // Distinct, odd (hence non-zero) seed per clause lane
  function automatic logic [31:0] lane_seed(input int unsigned lane);
    logic [31:0] mix;
    mix = 32'h6A09_E667 ^ (lane * 32'h9E37_79B9);
    mix = mix ^ (mix >> 13);
    return mix | 32'h0000_0001;
  endfunction

endpackage

// File: rtl/prng_lane.sv
module prng_lane #(
  parameter int unsigned         W    = 16,
  parameter logic [W-1:0]        TAPS = 16'hB400,
  parameter logic [W-1:0]        SEED = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  // Galois LFSR advanced W steps per clock: a fresh word each cycle
  always_comb begin
    state_d = state_q;
    for (int i = 0; i < int'(W); i++) begin
      if (state_d[0]) state_d = (state_d >> 1) ^ TAPS;
      else            state_d = state_d >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign rnd_o = state_q;

endmodule

// File: rtl/patch_seq_ctrl.sv
module patch_seq_ctrl
  import patch_sel_pkg::*;
#(
  parameter int unsigned N_PATCHES = 9,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] pos_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(N_PATCHES - 1);

  sel_state_e       state_q;
  logic [IDX_W-1:0] pos_q;
  logic             done_q;

  assign accept_o = start_i && (state_q == SEL_IDLE);
  assign busy_o   = (state_q == SEL_SCAN);
  assign pos_o    = pos_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEL_IDLE;
      pos_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEL_IDLE: begin
          if (start_i) begin
            state_q <= SEL_SCAN;
            pos_q   <= '0;
          end
        end
        SEL_SCAN: begin
          if (pos_q == LAST_POS) begin
            state_q <= SEL_IDLE;
            done_q  <= 1'b1;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: state_q <= SEL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clause_reservoir.sv
module clause_reservoir #(
  parameter int unsigned N_PATCHES = 9,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned RND_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] pos_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  localparam int unsigned CNT_W  = $clog2(N_PATCHES + 1);
  localparam int unsigned PROD_W = RND_W + CNT_W;

  logic [CNT_W-1:0]  seen_q;
  logic [CNT_W-1:0]  seen_nxt;
  logic [IDX_W-1:0]  idx_q;
  logic [PROD_W-1:0] scaled;
  logic              take;

  assign seen_nxt = seen_q + 1'b1;
  // keep with probability 1/k: rnd * k must stay below 2^RND_W
  assign scaled   = {{CNT_W{1'b0}}, rnd_i} * {{RND_W{1'b0}}, seen_nxt};
  assign take     = (scaled[PROD_W-1:RND_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      seen_q <= '0;
      idx_q  <= '0;
    end else if (step_i && hit_i) begin
      seen_q <= seen_nxt;
      if (take) idx_q <= pos_i;
    end
  end

  assign idx_o = idx_q;
  assign any_o = (seen_q != '0);

endmodule

// File: rtl/patch_reservoir_sel.sv
module patch_reservoir_sel
  import patch_sel_pkg::*;
#(
  parameter int unsigned           N_CLAUSES = 40,
  parameter int unsigned           N_PATCHES = 9,
  parameter int unsigned           LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]     LFSR_TAPS = 16'hB400,
  parameter int unsigned           IDX_W     = (N_PATCHES > 1) ? $clog2(N_PATCHES) : 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  start_i,
  input  logic [N_CLAUSES-1:0][N_PATCHES-1:0]   match_i,
  output logic [N_CLAUSES-1:0][IDX_W-1:0]       idx_o,
  output logic [N_CLAUSES-1:0]                  any_o,
  output logic                                  done_o
);

  logic                                accept;
  logic                                busy;
  logic [IDX_W-1:0]                    pos;
  logic [N_CLAUSES-1:0][N_PATCHES-1:0] match_q;

  patch_seq_ctrl #(
    .N_PATCHES(N_PATCHES),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .busy_o  (busy),
    .pos_o   (pos),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     match_q <= '0;
    else if (accept) match_q <= match_i;
  end

  for (genvar c = 0; c < int'(N_CLAUSES); c++) begin : g_lane
    localparam logic [31:0] SEED32 = lane_seed(c);
    logic [LFSR_W-1:0] rnd;
    logic              hit;

    prng_lane #(
      .W   (LFSR_W),
      .TAPS(LFSR_TAPS),
      .SEED(SEED32[LFSR_W-1:0])
    ) u_prng (
      .clk_i(clk_i),
      .rst_ni(rst_ni),
      .rnd_o(rnd)
    );

    assign hit = match_q[c][pos];

    clause_reservoir #(
      .N_PATCHES(N_PATCHES),
      .IDX_W    (IDX_W),
      .RND_W    (LFSR_W)
    ) u_res (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (accept),
      .step_i(busy),
      .hit_i (hit),
      .pos_i (pos),
      .rnd_i (rnd),
      .idx_o (idx_o[c]),
      .any_o (any_o[c])
    );
  end

endmodule

// File: rtl/patch_reservoir_sel_chk.sv
module patch_reservoir_sel_chk #(
  parameter int unsigned N_CLAUSES = 40,
  parameter int unsigned N_PATCHES = 9,
  parameter int unsigned IDX_W     = 4
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                start_i,
  input logic                                busy_i,
  input logic [N_CLAUSES-1:0][N_PATCHES-1:0] snap_i,
  input logic [N_CLAUSES-1:0][IDX_W-1:0]     idx_i,
  input logic [N_CLAUSES-1:0]                any_i,
  input logic                                done_i
);

  localparam int unsigned CW = $clog2(N_PATCHES + 1) + 1;

  logic [CW-1:0] walk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                walk_cnt <= '0;
    else if (start_i && !busy_i) walk_cnt <= '0;
    else if (busy_i)             walk_cnt <= walk_cnt + 1'b1;
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i);

  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R2
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (walk_cnt == CW'(N_PATCHES)));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(snap_i));

  // R10
  hold_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i && !done_i) |=> ($stable(idx_i) && $stable(any_i)));

  for (genvar c = 0; c < int'(N_CLAUSES); c++) begin : g_cl
    // R3
    any_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (any_i[c] == (|snap_i[c])));

    // R4
    zero_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_i[c] |-> (idx_i[c] == '0));

    // R5
    pick_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && any_i[c]) |->
        ((int'(idx_i[c]) < int'(N_PATCHES)) && snap_i[c][idx_i[c]]));
  end

endmodule

bind patch_reservoir_sel patch_reservoir_sel_chk #(
  .N_CLAUSES(N_CLAUSES),
  .N_PATCHES(N_PATCHES),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_i (busy),
  .snap_i (match_q),
  .idx_i  (idx_o),
  .any_i  (any_o),
  .done_i (done_o)
);

// File: tb/sim_patch_reservoir_sel.sv
module sim_patch_reservoir_sel;

  localparam int NC = 40;
  localparam int NP = 9;
  localparam int IW = 4;

  typedef logic [NC-1:0][NP-1:0] mat_t;
  typedef struct {
    mat_t pat;
    int   due;
    int   kind;
  } exp_t;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start = 1'b0;
  mat_t                match = '0;
  logic [NC-1:0][IW-1:0] idx;
  logic [NC-1:0]       any;
  logic                done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  exp_t sb[$];
  int hist[NP];
  int two_lo = 0;
  int pair_eq = 0;
  logic [NC-1:0][IW-1:0] last_idx;
  logic [NC-1:0]         last_any;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  patch_reservoir_sel u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .start_i(start),
    .match_i(match),
    .idx_o  (idx),
    .any_o  (any),
    .done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Monitor: pops expected run on each done pulse
  always @(negedge clk) begin
    if (rst_ni && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, "R2 done cycle", cyc, e.due);
        for (int c = 0; c < NC; c++) begin
          int ones;
          ones = $countones(e.pat[c]);
          chk(any[c] == (ones != 0), "R3 any flag", int'(any[c]), int'(ones != 0));
          if (ones == 0)
            chk(idx[c] == 0, "R4 zero index", int'(idx[c]), 0);
          else if (ones == 1) begin
            int p1;
            p1 = 0;
            for (int p = 0; p < NP; p++) if (e.pat[c][p]) p1 = p;
            chk(int'(idx[c]) == p1, "R6 single match", int'(idx[c]), p1);
          end else
            chk(int'(idx[c]) < NP && e.pat[c][idx[c]], "R5 member pick", int'(idx[c]), -1);
          if (e.kind == 1 && int'(idx[c]) < NP) hist[idx[c]]++;
          if (e.kind == 1 && c < NC - 1 && idx[c] == idx[c+1]) pair_eq++;
          if (e.kind == 2 && idx[c] == 2) two_lo++;
        end
      end
      last_idx = idx;
      last_any = any;
    end
  end

  // Driver: issues a start and pushes the expected item
  task automatic run(input mat_t pat, input int kind);
    exp_t e;
    @(negedge clk);
    start = 1'b1;
    match = pat;
    e.pat = pat; e.due = cyc + NP + 1; e.kind = kind;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    match = '0;
    repeat (NP + 1) @(negedge clk);
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  function automatic mat_t rand_mat();
    mat_t m;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < NP; p++)
        m[c][p] = ($urandom_range(0, 3) == 0);
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mat_t m;
    for (int p = 0; p < NP; p++) hist[p] = 0;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 reset done", int'(done), 0);
    chk(any == '0, "R11 reset any", int'(any != '0), 0);
    chk(idx == '0, "R11 reset idx", int'(idx != '0), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R6: single bits, one empty row
    m = '0;
    for (int c = 0; c < NC - 1; c++) m[c][c % NP] = 1'b1;
    run(m, 0);
    // R1: fresh start clears previous results
    m = '0;
    m[0] = '1;
    run(m, 0);
    chk(any[5] == 1'b0 && idx[5] == 0, "R1 cleared on start", int'(any[5]), 0);
    // R5 random sparse matrices
    for (int i = 0; i < 30; i++) run(rand_mat(), 0);
    // R6 first and last position only
    m = '0;
    for (int c = 0; c < NC; c++) m[c][(c % 2) ? NP - 1 : 0] = 1'b1;
    run(m, 0);

    // R10 hold after done
    run(rand_mat(), 0);
    repeat (5) @(negedge clk);
    chk(idx == last_idx, "R10 idx hold", int'(idx != last_idx), 0);
    chk(any == last_any, "R10 any hold", int'(any != last_any), 0);

    // R9 start mid-walk with different matrix
    begin
      exp_t e;
      m = '0;
      for (int c = 0; c < NC; c += 2) m[c] = '1;
      @(negedge clk);
      start = 1'b1; match = m;
      e.pat = m; e.due = cyc + NP + 1; e.kind = 0;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; match = '1;
      @(negedge clk);
      start = 1'b0;
      repeat (NP + 4) @(negedge clk);
      chk(any[1] == 1'b0, "R9 ignored start", int'(any[1]), 0);
      chk(sb.size() == 0, "R9 run completed", sb.size(), 0);
    end

    // R7 R8 statistics
    for (int i = 0; i < 300; i++) run('1, 1);
    m = '0;
    for (int c = 0; c < NC; c++) begin m[c][2] = 1'b1; m[c][7] = 1'b1; end
    for (int i = 0; i < 200; i++) run(m, 2);

    for (int p = 0; p < NP; p++)
      chk(hist[p] >= 1000 && hist[p] <= 1667, "R7 uniform histogram", hist[p], 1333);
    chk(two_lo >= 3400 && two_lo <= 4600, "R7 two-match split", two_lo, 4000);
    chk(pair_eq < 2500, "R8 clause independence", pair_eq, 1300);
    chk(sb.size() == 0, "R2 all runs done", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule